// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block carries out one complete exchange with a serial NOR flash over a single-lane SPI link in mode 0. The host offers a 13-bit command descriptor, a 24-bit address, a byte count and a clock divisor through a start/ready handshake. The block then lowers chip select and clocks out the opcode. It adds an address phase and zero-filled dummy bytes when the descriptor asks for them, and then either streams bytes out to the flash or collects bytes from it. Every byte on the wire is a full-duplex 8-bit frame.

The descriptor is laid out as follows: bits [7:0] hold the opcode, bits [10:8] hold a dummy-byte count from 0 to 7, bit 11 requests a three-byte address, and bit 12 selects the direction of the data phase (0 reads from the flash, 1 writes to it). One engine can therefore issue any flash command: write enable, status reads, identification, erase, page program and data reads.

Outgoing data arrives on a valid/ready stream. The block raises `tx_ready` only when it needs the next data byte and consumes a byte on a cycle where `tx_valid` and `tx_ready` are both high. If no byte is offered, the serial clock stops low and chip select stays low until one arrives, so the upstream side may stall freely. Received bytes leave on `rx_valid`/`rx_data` for exactly one cycle each, with no back-pressure, and the consumer must take them when they appear.

Top module: `spi_flash_seq`

## Requirements
- R1: After a start is accepted, chip select falls before the first rising SCLK edge, and the first byte on MOSI is the descriptor opcode (bits [7:0]), shifted most significant bit first.
- R2: When descriptor bit 11 is set, three address bytes follow the opcode in the order address[23:16], [15:8], [7:0]. When it is clear, no address bytes are sent.
- R3: After the opcode (or the address, when present), exactly descriptor[10:8] bytes of value 0x00 are sent.
- R4: When descriptor bit 12 is 0, the data phase sends `cmd_len` filler bytes of 0x00. Each byte assembled from MISO (sampled on rising SCLK, MSB first) appears on `rx_data` with `rx_valid` high for one cycle.
- R5: When descriptor bit 12 is 1, the data phase sends `cmd_len` bytes taken in order from the tx stream. While `tx_valid` is low, SCLK stays low and chip select stays low.
- R6: A byte count of zero skips the data phase, and the transaction still ends with chip select high.
- R7: Each SCLK half period lasts sclk_div/2 system clocks, with bit 0 of the divisor ignored and values below 2 treated as 2. SCLK idles low, and MOSI does not change while SCLK is high.
- R8: Chip select rises only after the final falling SCLK edge of the last byte. SCLK never pulses while chip select is high. Chip select stays high for at least one SCLK period before `start_ready` returns.
- R9: After reset, `spi_cs_n` is 1, `spi_sclk` is 0, `start_ready` is 1, and `rx_valid` and `tx_ready` are 0.
- R10: Descriptor, address, count and divisor are taken only in the accepting cycle. Changes to them during a transaction have no effect on the wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Host requests a transaction |
| start_ready | output | 1 | Block idle and able to accept a transaction |
| cmd_desc | input | 13 | Command descriptor (opcode, dummy count, address flag, direction) |
| cmd_addr | input | 24 | Flash address |
| cmd_len | input | LEN_W | Number of data bytes |
| sclk_div | input | DIV_W | System clocks per SCLK period (even) |
| tx_valid | input | 1 | Outgoing data byte available |
| tx_ready | output | 1 | Block takes the outgoing byte this cycle if valid |
| tx_data | input | 8 | Outgoing data byte |
| rx_valid | output | 1 | Received byte present (one cycle) |
| rx_data | output | 8 | Received byte |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The hardest situations to reach are the phase transitions at their edges. These are a dummy count of seven right after an address, a zero-length data phase following dummy bytes, and a write whose source stalls in the middle of a byte gap. The stimulus sweeps every combination of address flag, dummy count {0,1,3,7}, direction, length 0 to 3 and four divisors, including the odd and zero divisors. For three-byte writes, the tx stream is throttled on a repeating pattern, which forces the engine to wait with chip select low. A behavioural flash model on the wire captures every MOSI byte and drives a known MISO pattern, so the complete frame and every received byte are compared with values computed from the descriptor.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPC,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_GAP
  } phase_e;

  typedef struct packed {
    logic       dir_tx;
    logic       has_addr;
    logic [2:0] dummy;
    logic [7:0] opcode;
  } cmd_cfg_t;

endpackage

// File: rtl/flash_desc_decode.sv
module flash_desc_decode
  import spi_seq_pkg::*;
(
  input  logic [12:0] desc,
  output cmd_cfg_t    cfg
);
  // Field positions are fixed by the descriptor format.
  always_comb begin
    cfg.opcode   = desc[7:0];
    cfg.dummy    = desc[10:8];
    cfg.has_addr = desc[11];
    cfg.dir_tx   = desc[12];
  end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [7:0]       load_byte,
  input  logic [DIV_W-1:0] half,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_byte
);
  localparam int EDGES = 16;
  localparam int PH_W  = $clog2(EDGES);

  logic [7:0]       sh_q;
  logic [DIV_W-1:0] cnt_q;
  logic [PH_W-1:0]  ph_q;
  logic             half_end;

  assign half_end = (cnt_q == half - 1'b1);
  assign mosi     = sh_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      cnt_q   <= '0;
      ph_q    <= '0;
      sclk    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (load && !busy) begin
        sh_q  <= load_byte;
        cnt_q <= '0;
        ph_q  <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        if (half_end) begin
          cnt_q <= '0;
          ph_q  <= ph_q + 1'b1;
          if (!ph_q[0]) begin
            sclk    <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sclk <= 1'b0;
            sh_q <= {sh_q[6:0], 1'b0};
            if (ph_q == PH_W'(EDGES - 1)) begin
              busy <= 1'b0;
              done <= 1'b1;
            end
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R7
  mosi_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  // R7
  sclk_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> busy);

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
  import spi_seq_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_valid,
  output logic             start_ready,
  input  logic [12:0]      cmd_desc,
  input  logic [23:0]      cmd_addr,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [DIV_W-1:0] sclk_div,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [7:0]       tx_data,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             spi_cs_n,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int ADDR_BYTES = 3;
  localparam int IDX_W      = 3;
  localparam int GAP_W      = DIV_W + 1;

  phase_e           phase_q, nxt_ph, post_addr_ph, post_dummy_ph;
  cmd_cfg_t         cfg_q, dec_cfg;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] rem_q;
  logic [IDX_W-1:0] idx_q, nxt_idx;
  logic [DIV_W-1:0] half_q, half_in;
  logic [GAP_W-1:0] gcnt_q;
  logic             inflight_q;
  logic             active, tx_phase, eng_load, eng_busy, eng_done;
  logic [7:0]       load_byte, eng_rx;

  flash_desc_decode u_dec (
    .desc (cmd_desc),
    .cfg  (dec_cfg)
  );

  spi_byte_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (eng_load),
    .load_byte (load_byte),
    .half      (half_q),
    .miso      (spi_miso),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .busy      (eng_busy),
    .done      (eng_done),
    .rx_byte   (eng_rx)
  );

  assign half_in  = ((sclk_div >> 1) == '0) ? DIV_W'(1) : (sclk_div >> 1);
  assign active   = (phase_q == PH_OPC) || (phase_q == PH_ADDR) ||
                    (phase_q == PH_DUMMY) || (phase_q == PH_DATA);
  assign tx_phase = (phase_q == PH_DATA) && cfg_q.dir_tx;
  assign tx_ready = tx_phase && !inflight_q;
  assign eng_load = active && !inflight_q && (!tx_phase || tx_valid);

  assign start_ready = (phase_q == PH_IDLE);
  assign rx_valid    = eng_done && (phase_q == PH_DATA) && !cfg_q.dir_tx;
  assign rx_data     = eng_rx;

  always_comb begin
    load_byte = 8'h00;
    case (phase_q)
      PH_OPC:  load_byte = cfg_q.opcode;
      PH_ADDR: begin
        case (idx_q)
          3'd0:    load_byte = addr_q[23:16];
          3'd1:    load_byte = addr_q[15:8];
          default: load_byte = addr_q[7:0];
        endcase
      end
      PH_DATA: load_byte = cfg_q.dir_tx ? tx_data : 8'h00;
      default: load_byte = 8'h00;
    endcase
  end

  assign post_dummy_ph = (rem_q != '0) ? PH_DATA : PH_GAP;
  assign post_addr_ph  = (cfg_q.dummy != '0) ? PH_DUMMY : post_dummy_ph;

  always_comb begin
    nxt_ph  = phase_q;
    nxt_idx = idx_q;
    if (eng_done) begin
      case (phase_q)
        PH_OPC: begin
          nxt_idx = '0;
          nxt_ph  = cfg_q.has_addr ? PH_ADDR : post_addr_ph;
        end
        PH_ADDR: begin
          if (idx_q == IDX_W'(ADDR_BYTES - 1)) begin
            nxt_idx = '0;
            nxt_ph  = post_addr_ph;
          end else begin
            nxt_idx = idx_q + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (idx_q == cfg_q.dummy - 3'd1) begin
            nxt_idx = '0;
            nxt_ph  = post_dummy_ph;
          end else begin
            nxt_idx = idx_q + 1'b1;
          end
        end
        PH_DATA: if (rem_q == LEN_W'(1)) nxt_ph = PH_GAP;
        default: ;
      endcase
    end
    if (phase_q == PH_GAP && gcnt_q == {half_q, 1'b0} - 1'b1) nxt_ph = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      cfg_q      <= '0;
      addr_q     <= '0;
      rem_q      <= '0;
      idx_q      <= '0;
      half_q     <= DIV_W'(1);
      gcnt_q     <= '0;
      inflight_q <= 1'b0;
      spi_cs_n   <= 1'b1;
    end else begin
      phase_q <= nxt_ph;
      idx_q   <= nxt_idx;
      if (eng_load)      inflight_q <= 1'b1;
      else if (eng_done) inflight_q <= 1'b0;
      if (eng_done && phase_q == PH_DATA) rem_q <= rem_q - 1'b1;
      if (phase_q == PH_GAP) gcnt_q <= gcnt_q + 1'b1;
      if (phase_q != PH_GAP && nxt_ph == PH_GAP) begin
        spi_cs_n <= 1'b1;
        gcnt_q   <= '0;
      end
      if (phase_q == PH_IDLE && start_valid) begin
        cfg_q    <= dec_cfg;
        addr_q   <= cmd_addr;
        rem_q    <= cmd_len;
        half_q   <= half_in;
        idx_q    <= '0;
        spi_cs_n <= 1'b0;
        phase_q  <= PH_OPC;
      end
    end
  end

  // R8
  cs_idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R8
  ready_cs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> spi_cs_n);

  // R4
  rx_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!spi_cs_n && !tx_ready));

  // R5
  tx_take_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> (!spi_cs_n && !tx_ready));

  // R8
  cs_rise_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> ($past(!spi_sclk) && !spi_sclk));

endmodule

// File: tb/tb_spi_flash_seq.sv
module tb_spi_flash_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;
  localparam int LEN_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_valid = 1'b0, start_ready;
  logic [12:0] cmd_desc = '0;
  logic [23:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic [DIV_W-1:0] sclk_div = 8'd6;
  logic tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = '0;
  logic rx_valid;
  logic [7:0] rx_data;
  logic spi_cs_n, spi_sclk, spi_mosi;
  logic spi_miso = 1'b0;

  int tests = 0, fails = 0;
  bit finished = 0;

  spi_flash_seq #(.DIV_W(DIV_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .cmd_desc(cmd_desc), .cmd_addr(cmd_addr), .cmd_len(cmd_len), .sclk_div(sclk_div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(input int k);
    return 8'h3C + 8'(k * 41);
  endfunction

  function automatic logic [7:0] txb(input int j);
    return 8'hC3 ^ 8'(j * 29);
  endfunction

  // wire monitor / flash model state
  logic [7:0] cap [0:31];
  logic [7:0] rxcap [0:15];
  int ncap = 0, nrx = 0, nbits = 0, hirun = 0, gap = 0;
  int cur_h = 1, last_h = 1, tx_idx = 0, cyc = 0;
  bit have_prev = 0, tx_en = 0, stall_en = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0;
  logic [7:0] sh = '0;

  always @(posedge clk) if (tx_valid && tx_ready) tx_idx = tx_idx + 1;

  always @(negedge clk) begin
    cyc++;
    tx_data  = txb(tx_idx);
    tx_valid = tx_en && (!stall_en || (cyc % 7) < 3);
    if (rst_n) begin
      if (prev_cs && !spi_cs_n) begin
        if (have_prev) check(gap >= 2 * last_h, "R8", "cs high gap", gap, 2 * last_h);
        have_prev = 1;
        nbits = 0; ncap = 0;
        spi_miso = resp(0)[7];
      end
      if (!prev_cs && spi_cs_n) begin
        check(!spi_sclk && (nbits % 8) == 0, "R8", "cs rise mid byte", nbits, 0);
        last_h = cur_h;
      end
      if (spi_cs_n) gap++; else gap = 0;
      if (!prev_sclk && spi_sclk) begin
        if (spi_cs_n) check(0, "R8", "sclk while cs high", 1, 0);
        sh = {sh[6:0], spi_mosi};
        nbits++;
        if ((nbits % 8) == 0 && ncap < 32) begin cap[ncap] = sh; ncap++; end
        hirun = 0;
      end
      if (spi_sclk) hirun++;
      if (prev_sclk && !spi_sclk) begin
        check(hirun == cur_h, "R7", "sclk high length", hirun, cur_h);
        spi_miso = resp(nbits / 8)[7 - (nbits % 8)];
      end
      if (rx_valid && nrx < 16) begin rxcap[nrx] = rx_data; nrx++; end
      prev_cs = spi_cs_n;
      prev_sclk = spi_sclk;
    end
  end

  task automatic run_txn(input logic [12:0] desc, input logic [23:0] addr,
                         input int len, input int div, input bit stall);
    logic [7:0] exp [0:31];
    int n = 0, na, nd, bad_i = -1;
    logic [7:0] bad_a = '0, bad_e = '0;
    string req;
    na = desc[11] ? 3 : 0;
    nd = int'(desc[10:8]);
    exp[n++] = desc[7:0];
    if (desc[11]) begin exp[n++] = addr[23:16]; exp[n++] = addr[15:8]; exp[n++] = addr[7:0]; end
    for (int i = 0; i < nd; i++) exp[n++] = 8'h00;
    for (int j = 0; j < len; j++) exp[n++] = desc[12] ? txb(j) : 8'h00;
    do @(negedge clk); while (!start_ready);
    tx_idx = 0; nrx = 0; tx_en = desc[12]; stall_en = stall;
    cur_h = ((div >> 1) == 0) ? 1 : (div >> 1);
    start_valid = 1'b1; cmd_desc = desc; cmd_addr = addr;
    cmd_len = LEN_W'(len); sclk_div = DIV_W'(div);
    @(negedge clk);
    // R10: scramble request fields after acceptance
    start_valid = 1'b0; cmd_desc = ~desc; cmd_addr = ~addr; cmd_len = '1; sclk_div = 8'd14;
    do @(negedge clk); while (!start_ready);
    tx_en = 0;
    check(ncap == n, (len == 0) ? "R6" : "R8", "frame byte count", ncap, n);
    for (int i = 0; i < n && i < ncap; i++)
      if (bad_i < 0 && cap[i] !== exp[i]) begin bad_i = i; bad_a = cap[i]; bad_e = exp[i]; end
    if (bad_i < 0) req = "R1";
    else if (bad_i == 0) req = "R1";
    else if (bad_i < 1 + na) req = "R2";
    else if (bad_i < 1 + na + nd) req = "R3";
    else req = desc[12] ? "R5" : "R4";
    check(bad_i < 0, req, "mosi byte", bad_a, bad_e);
    check(bad_i < 0, "R10", "frame after field change", bad_i, -1);
    if (!desc[12]) begin
      check(nrx == len, "R4", "rx byte count", nrx, len);
      for (int j = 0; j < len && j < nrx; j++)
        check(rxcap[j] == resp(1 + na + nd + j), "R4", "rx byte", rxcap[j], resp(1 + na + nd + j));
    end else begin
      check(tx_idx == len, "R5", "tx bytes taken", tx_idx, len);
      check(nrx == 0, "R5", "rx during write", nrx, 0);
    end
  endtask

  initial begin
    int divs [4] = '{2, 6, 7, 0};
    int dums [4] = '{0, 1, 3, 7};
    repeat (3) @(negedge clk);
    // R9 reset state
    check(spi_cs_n == 1'b1, "R9", "cs_n at reset", spi_cs_n, 1);
    check(spi_sclk == 1'b0, "R9", "sclk at reset", spi_sclk, 0);
    check(start_ready == 1'b1, "R9", "start_ready at reset", start_ready, 1);
    check(rx_valid == 1'b0 && tx_ready == 1'b0, "R9", "rx_valid/tx_ready at reset",
          {rx_valid, tx_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int d = 0; d < 4; d++)
      for (int a = 0; a < 2; a++)
        for (int m = 0; m < 4; m++)
          for (int dir = 0; dir < 2; dir++)
            for (int len = 0; len < 4; len++) begin
              logic [7:0] opc;
              opc = 8'(a * 16 + m * 3 + dir * 64 + len) ^ 8'h5A;
              run_txn({dir[0], a[0], dums[m][2:0], opc},
                      24'(32'h00A1B2C3 * (len + 1)) ^ 24'(m),
                      len, divs[d], (dir == 1) && (len == 3));
            end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule